// File: doc/BRIEF.md
# Tuner Control Register Interface over I2C

This block is a serial-bus slave that sets up a frequency-synthesis tuner. A bus master addresses it, then writes data bytes that carry a 15-bit divider ratio, four loop-control bits and an 8-bit port-drive pattern. The master can also read back a status byte that packs a power-up flag, the loop lock flag, three live port levels and a 3-bit converter code. SCL and SDA are oversampled by the system clock through a synchronizer. START, STOP, bit timing and acknowledge are all decoded in that clock domain.

No sub-address pointer is used. The leading bit of each write byte that opens a pair decides whether the pair is a frequency pair or a control pair. The second byte of a pair is then taken by position. Any number of pairs can follow one address byte. A byte cut short by a STOP changes nothing. The divider ratio reaches the output as one word once its low byte completes.

Top module: `tunerI2cSlave`

## Requirements
- R1: An address byte `1,1,0,0,0,m1,m0,rw` (MSB first) is acknowledged by pulling SDA low during the ninth clock when `{m1,m0}` is 00 or equals `selAddr`. Any other address, including a wrong fixed prefix, gets no acknowledge, and the data bytes that follow are ignored.
- R2: A write byte that opens a pair with leading bit 0 carries ratio bits 14..8 in its low seven bits. The next byte carries ratio bits 7..0. `divRatio` stays unchanged after the first byte and takes the full 15-bit value once the second byte completes.
- R3: A write byte that opens a pair with leading bit 1 is a control byte. Bit 6 drives `pumpHigh`, bit 5 drives `testMode`, bit 4 drives `pumpOff` and bit 0 drives `ampOff`; bits 3..1 are ignored. The byte after it is loaded into `portDrive`, where bit n is port n and 1 means driven on.
- R4: After one address byte, any number of pairs may follow in any order. Once the second byte of a pair completes, the next byte is classified again by its leading bit.
- R5: A STOP that arrives part-way through a byte leaves the register that byte was aimed at unchanged. A STOP between the two bytes of a frequency pair leaves `divRatio` unchanged.
- R6: In read mode the slave sends the status byte MSB first: bit 7 is the power-up flag, bit 6 is `lockIn`, bits 5..3 are `portSense[2:0]` (ports 7, 5, 4) and bits 2..0 are `adcCode`.
- R7: The power-up flag reads 1 after reset. A write transaction does not clear it. It clears only when a read transaction ends with a STOP.
- R8: After reset, `portDrive`, `divRatio` and all four control outputs are 0, and `sdaOe` is 0.
- R9: In read mode, an acknowledge from the master makes the slave send another status byte. A not-acknowledge leaves SDA released until the next START.
- R10: Each data byte of an addressed write is acknowledged by pulling SDA low. The slave changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOut | output | 1 | Data value driven when enabled (always 0) |
| sdaOe | output | 1 | 1 pulls SDA low |
| selAddr | input | 2 | Selectable address pair accepted besides 00 |
| portSense | input | 3 | Live levels of ports 7, 5, 4 |
| lockIn | input | 1 | Loop lock flag |
| adcCode | input | 3 | Converter code for the status byte |
| divRatio | output | RATIO_W | Divider ratio |
| pumpHigh | output | 1 | Charge-pump high current select |
| testMode | output | 1 | Comparator test routing select |
| pumpOff | output | 1 | Charge-pump disable |
| ampOff | output | 1 | Drive amplifier off |
| portDrive | output | 8 | Port drive pattern |

## Verification
The bench builds the block with its default parameters: a 15-bit ratio and a two-stage synchronizer. The bus quarter-bit is six system clocks, so a full run is short enough to cover every case below. That makes it possible to sweep all 32 combinations of address-select input, address pair and direction, plus a wrong prefix. It also covers all 16 settings of the four control bits, paired with computed port patterns, and all 8 converter codes with varied lock and port levels over two-byte reads. Frequency values are spread across the 15-bit range, including both extremes. Chained pairs, a STOP inside a byte and a STOP between pair bytes are each checked at the outputs.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [2:0] {
    COMMIT_NONE,
    COMMIT_FREQ_HI,
    COMMIT_FREQ_LO,
    COMMIT_CTRL,
    COMMIT_PORTS
  } commitKind_t;

  typedef struct packed {
    logic        shiftIn;
    logic        loadStatus;
    logic        shiftOut;
    commitKind_t commit;
    logic        clrPor;
  } dpStrobe_t;
endpackage

// File: rtl/tunerBusCtrl.sv
module tunerBusCtrl
  import tuner_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_PREFIX  = 5'b11000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRaw,
  input  logic       sdaRaw,
  input  logic [1:0] selAddr,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       ackDrive,
  output logic       txActive
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(7);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRX, ST_WACK, ST_TX, ST_MACK
  } busState_t;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclRaw};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaRaw};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS   = sclPipe[SYNC_STAGES-1];
  assign sdaS   = sdaPipe[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead, rdActive, expectSecond, secondCtrl, masterAck;
  logic             byteDone, addrOk;

  assign byteDone = sclFall & (bitCnt == FULL_BYTE);
  assign addrOk   = (rxByte[7:3] == DEV_PREFIX) &&
                    ((rxByte[2:1] == 2'b00) || (rxByte[2:1] == selAddr));

  always_comb begin
    strobe         = '0;
    strobe.shiftIn = sclRise & ((state == ST_ADDR) || (state == ST_WRX));
    strobe.loadStatus = sclFall & (((state == ST_ADDR_ACK) & isRead) |
                                   ((state == ST_MACK) & masterAck));
    strobe.shiftOut = sclFall & (state == ST_TX) & (bitCnt != LAST_TX);
    strobe.clrPor   = stopCond & rdActive;
    if (!startCond && !stopCond && (state == ST_WRX) && byteDone) begin
      if (expectSecond) strobe.commit = secondCtrl ? COMMIT_PORTS : COMMIT_FREQ_LO;
      else              strobe.commit = rxByte[7] ? COMMIT_CTRL : COMMIT_FREQ_HI;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      isRead       <= 1'b0;
      rdActive     <= 1'b0;
      expectSecond <= 1'b0;
      secondCtrl   <= 1'b0;
      masterAck    <= 1'b0;
      ackDrive     <= 1'b0;
      txActive     <= 1'b0;
    end else if (startCond) begin
      state        <= ST_ADDR;
      bitCnt       <= '0;
      ackDrive     <= 1'b0;
      txActive     <= 1'b0;
      rdActive     <= 1'b0;
      expectSecond <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      rdActive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (addrOk) begin
              state    <= ST_ADDR_ACK;
              ackDrive <= 1'b1;
              isRead   <= rxByte[0];
              rdActive <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (isRead) begin
            state    <= ST_TX;
            txActive <= 1'b1;
          end else begin
            state <= ST_WRX;
          end
        end
        ST_WRX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            state    <= ST_WACK;
            ackDrive <= 1'b1;
            if (expectSecond) expectSecond <= 1'b0;
            else begin
              expectSecond <= 1'b1;
              secondCtrl   <= rxByte[7];
            end
          end
        end
        ST_WACK: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          state    <= ST_WRX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST_TX) begin
            txActive <= 1'b0;
            state    <= ST_MACK;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            if (masterAck) begin
              state    <= ST_TX;
              txActive <= 1'b1;
              bitCnt   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tunerRegs.sv
module tunerRegs
  import tuner_pkg::*;
#(
  parameter int RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               sdaBit,
  input  logic               lockIn,
  input  logic [2:0]         portSense,
  input  logic [2:0]         adcCode,
  output logic [7:0]         rxByte,
  output logic               txMsb,
  output logic               porFlag,
  output logic [RATIO_W-1:0] divRatio,
  output logic               pumpHigh,
  output logic               testMode,
  output logic               pumpOff,
  output logic               ampOff,
  output logic [7:0]         portDrive
);
  localparam int HI_W = RATIO_W - 8;

  logic [7:0]      rxShift, txShift;
  logic [HI_W-1:0] freqHi;
  logic [7:0]      statusByte;

  assign statusByte = {porFlag, lockIn, portSense, adcCode};
  assign rxByte     = rxShift;
  assign txMsb      = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      freqHi    <= '0;
      divRatio  <= '0;
      pumpHigh  <= 1'b0;
      testMode  <= 1'b0;
      pumpOff   <= 1'b0;
      ampOff    <= 1'b0;
      portDrive <= '0;
      porFlag   <= 1'b1;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (strobe.loadStatus)    txShift <= statusByte;
      else if (strobe.shiftOut) txShift <= {txShift[6:0], 1'b1};
      if (strobe.clrPor) porFlag <= 1'b0;
      unique case (strobe.commit)
        COMMIT_FREQ_HI: freqHi   <= rxShift[HI_W-1:0];
        COMMIT_FREQ_LO: divRatio <= {freqHi, rxShift};
        COMMIT_CTRL: begin
          pumpHigh <= rxShift[6];
          testMode <= rxShift[5];
          pumpOff  <= rxShift[4];
          ampOff   <= rxShift[0];
        end
        COMMIT_PORTS: portDrive <= rxShift;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tunerI2cSlave.sv
module tunerI2cSlave
  import tuner_pkg::*;
#(
  parameter int RATIO_W     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOut,
  output logic               sdaOe,
  input  logic [1:0]         selAddr,
  input  logic [2:0]         portSense,
  input  logic               lockIn,
  input  logic [2:0]         adcCode,
  output logic [RATIO_W-1:0] divRatio,
  output logic               pumpHigh,
  output logic               testMode,
  output logic               pumpOff,
  output logic               ampOff,
  output logic [7:0]         portDrive
);
  dpStrobe_t  dpStrobe;
  logic       sdaBit, ackDrive, txActive, txMsb, porFlag;
  logic [7:0] rxByte;

  tunerBusCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .selAddr(selAddr), .rxByte(rxByte), .strobe(dpStrobe),
    .sdaBit(sdaBit), .ackDrive(ackDrive), .txActive(txActive)
  );

  tunerRegs #(.RATIO_W(RATIO_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(dpStrobe), .sdaBit(sdaBit),
    .lockIn(lockIn), .portSense(portSense), .adcCode(adcCode),
    .rxByte(rxByte), .txMsb(txMsb), .porFlag(porFlag),
    .divRatio(divRatio), .pumpHigh(pumpHigh), .testMode(testMode),
    .pumpOff(pumpOff), .ampOff(ampOff), .portDrive(portDrive)
  );

  assign sdaOut = 1'b0;
  assign sdaOe  = ackDrive | (txActive & ~txMsb);
endmodule

// File: rtl/tunerI2cSlaveChk.sv
module tunerI2cSlaveChk
  import tuner_pkg::*;
#(
  parameter int RATIO_W = 15
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclIn,
  input logic               sdaOe,
  input logic [RATIO_W-1:0] divRatio,
  input logic [7:0]         portDrive,
  input dpStrobe_t          strobe,
  input logic               porFlag
);
  // R2: ratio output moves only after a low-byte commit
  assert_ratio_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divRatio) |-> $past(strobe.commit == COMMIT_FREQ_LO));

  // R5: port pattern moves only after a completed port byte
  assert_port_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portDrive) |-> $past(strobe.commit == COMMIT_PORTS));

  // R7: power-up flag falls only on a read-ending STOP
  assert_por_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(porFlag) |-> $past(strobe.clrPor));

  // R7: once cleared the flag never comes back without reset
  assert_por_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !porFlag |=> !porFlag);

  // R10: SDA drive changes only while SCL is low
  assert_sda_in_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind tunerI2cSlave tunerI2cSlaveChk #(.RATIO_W(RATIO_W)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .divRatio(divRatio), .portDrive(portDrive), .strobe(dpStrobe),
  .porFlag(porFlag)
);

// File: tb/tb_tunerI2cSlave.sv
module tb_tunerI2cSlave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] selAddr = 2'd0;
  logic [2:0] portSense = 3'd0, adcCode = 3'd0;
  logic lockIn = 1'b0;
  logic sdaOut, sdaOe, pumpHigh, testMode, pumpOff, ampOff;
  logic [14:0] divRatio;
  logic [7:0] portDrive;
  logic sdaBus;

  int checks = 0, failures = 0;
  bit done = 0;

  assign sdaBus = sdaM & ~sdaOe;
  always #2.5 clk = ~clk;

  tunerI2cSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .selAddr(selAddr), .portSense(portSense), .lockIn(lockIn),
    .adcCode(adcCode), .divRatio(divRatio), .pumpHigh(pumpHigh),
    .testMode(testMode), .pumpOff(pumpOff), .ampOff(ampOff), .portDrive(portDrive)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; sclM = 1; tick(Q);
    sdaM = 0; tick(Q);
    sclM = 0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 0; tick(Q);
    sclM = 1; tick(Q);
    sdaM = 1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q);
    sclM = 1; tick(2 * Q);
    sclM = 0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1; tick(Q);
    sclM = 1; tick(Q);
    ack = ~sdaBus;
    tick(Q);
    sclM = 0; tick(Q);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    sdaM = 1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sclM = 1; tick(Q);
      b = {b[6:0], sdaBus};
      tick(Q); sclM = 0; tick(Q);
    end
    sdaM = ~mAck; tick(Q);
    sclM = 1; tick(2 * Q);
    sclM = 0; tick(Q);
    sdaM = 1;
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic ack;
    busStart();
    sendByte(8'hC1, ack);
    readByte(1'b0, s);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] st, st2;
    logic [14:0] expRatio;
    logic [7:0] expPorts;
    logic [3:0] expCtrl;
    tick(20);
    rstN = 1;
    tick(10);
    // R8 reset state
    check(divRatio == 0, "R8 ratio", 32'(divRatio), 0);
    check(portDrive == 0, "R8 ports", 32'(portDrive), 0);
    check({pumpHigh, testMode, pumpOff, ampOff} == 0, "R8 ctrl",
          32'({pumpHigh, testMode, pumpOff, ampOff}), 0);
    check(sdaOe == 0, "R8 sda", 32'(sdaOe), 0);

    // R7 write does not clear, read+STOP clears
    busStart(); sendByte(8'hC0, ack); sendByte(8'h80, ack); busStop();
    readStatus(st);
    check(st[7] == 1, "R7 por after write", 32'(st[7]), 1);
    readStatus(st);
    check(st[7] == 0, "R7 por after read stop", 32'(st[7]), 0);

    // R1 address sweep
    for (int s = 0; s < 4; s++) begin
      for (int ma = 0; ma < 4; ma++) begin
        for (int rw = 0; rw < 2; rw++) begin
          logic expAck;
          selAddr = 2'(s);
          expAck = (ma == 0) || (ma == s);
          busStart();
          sendByte({5'b11000, 2'(ma), 1'(rw)}, ack);
          check(ack == expAck, "R1 address match", 32'(ack), 32'(expAck));
          if (ack && rw == 1) readByte(1'b0, st);
          busStop();
        end
      end
    end
    selAddr = 2'd0;
    busStart(); sendByte(8'hD0, ack);
    check(ack == 0, "R1 bad prefix", 32'(ack), 0);
    sendByte(8'h05, ack); sendByte(8'h55, ack); busStop();
    check(divRatio == 0, "R1 ignored data", 32'(divRatio), 0);

    // R2 / R10 frequency sweep
    expRatio = 0;
    for (int k = 0; k < 10; k++) begin
      logic [14:0] r;
      r = (k == 8) ? 15'h7FFF : (k == 9) ? 15'h0000 : 15'((k * 4681 + 3) & 32'h7FFF);
      busStart(); sendByte(8'hC0, ack);
      sendByte({1'b0, r[14:8]}, ack);
      check(ack == 1, "R10 ack byte2", 32'(ack), 1);
      check(divRatio == expRatio, "R2 held after byte2", 32'(divRatio), 32'(expRatio));
      sendByte(r[7:0], ack);
      check(ack == 1, "R10 ack byte3", 32'(ack), 1);
      busStop();
      expRatio = r;
      check(divRatio == expRatio, "R2 ratio", 32'(divRatio), 32'(expRatio));
    end

    // R3 control and port sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p;
      p = 8'((k * 37) ^ 8'h5A);
      busStart(); sendByte(8'hC0, ack);
      sendByte({1'b1, 1'(k >> 3), 1'(k >> 2), 1'(k >> 1), 3'b111, 1'(k)}, ack);
      expCtrl = 4'(k);
      check({pumpHigh, testMode, pumpOff, ampOff} == expCtrl, "R3 ctrl bits",
            32'({pumpHigh, testMode, pumpOff, ampOff}), 32'(expCtrl));
      sendByte(p, ack);
      busStop();
      expPorts = p;
      check(portDrive == expPorts, "R3 ports", 32'(portDrive), 32'(expPorts));
    end

    // R4 chained pairs in one transaction
    busStart(); sendByte(8'hC0, ack);
    sendByte(8'hC9, ack); sendByte(8'hF0, ack);
    sendByte(8'h12, ack); sendByte(8'h34, ack);
    sendByte(8'h7F, ack); sendByte(8'hEE, ack);
    busStop();
    check(divRatio == 15'h7FEE, "R4 chained ratio", 32'(divRatio), 32'h7FEE);
    check(portDrive == 8'hF0, "R4 chained ports", 32'(portDrive), 32'hF0);
    check({pumpHigh, testMode, pumpOff, ampOff} == 4'b1001, "R4 chained ctrl",
          32'({pumpHigh, testMode, pumpOff, ampOff}), 32'h9);

    // R5 stops inside a byte and between pair bytes
    busStart(); sendByte(8'hC0, ack);
    sendBit(0); sendBit(1); sendBit(0);
    busStop();
    check(divRatio == 15'h7FEE, "R5 mid byte", 32'(divRatio), 32'h7FEE);
    busStart(); sendByte(8'hC0, ack); sendByte(8'h01, ack); busStop();
    check(divRatio == 15'h7FEE, "R5 between pair", 32'(divRatio), 32'h7FEE);
    busStart(); sendByte(8'hC0, ack); sendByte(8'h8E, ack);
    sendBit(0); sendBit(0); sendBit(1); sendBit(1); sendBit(0);
    busStop();
    check(portDrive == 8'hF0, "R5 ports mid byte", 32'(portDrive), 32'hF0);

    // R6 / R9 status sweep
    for (int k = 0; k < 8; k++) begin
      logic [7:0] expSt;
      adcCode = 3'(k); lockIn = 1'(k); portSense = ~3'(k);
      expSt = {1'b0, lockIn, portSense, adcCode};
      busStart(); sendByte(8'hC1, ack);
      readByte(1'b1, st);
      check(st == expSt, "R6 status", 32'(st), 32'(expSt));
      readByte(1'b0, st2);
      check(st2 == expSt, "R9 second status", 32'(st2), 32'(expSt));
      tick(Q);
      check(sdaOe == 0, "R9 released after nack", 32'(sdaOe), 0);
      busStop();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule